// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block sits between an 8-bit parallel image sensor and the rest of a capture path. The sensor drives a 14-bit bus together with separate frame-valid and line-valid qualifiers; no sync codes are embedded in the data. The block picks an 8-bit lane out of the bus and counts bytes and lines against the sensor qualifiers. It keeps a programmable rectangular window of each progressive frame, pairs the kept bytes into 16-bit YCbCr words, and emits them on a valid/ready stream. Each word carries a start-of-frame flag and an end-of-line flag.

A frame begins at each falling edge of frame-valid. Two interrupt pulses mark frame timing. The first pulse marks the start of a programmed line, and line 0 is a legal setting. The second pulse marks the end of the last kept line. All configuration arrives on static input ports, and window sizes are coded as count minus one.

The output stream has no back-pressure path to the sensor, because the sensor cannot be paused. Each word is offered with `out_valid` for exactly one cycle. The word is transferred only if `out_ready` is high in that same cycle. If `out_ready` is low, the word is lost and a sticky overflow flag is set. The input side is never stalled.

Top module: `cam_capture`

## Requirements
- R1: The data byte is taken from bus bits [2*cfg_shift+7 : 2*cfg_shift]. For example, setting 3 takes bits [13:6] and setting 0 takes bits [7:0].
- R2: A frame starts at a falling edge of `frame_valid`, and that edge resets the line count to 0. Before the first such edge, no word is produced and no interrupt fires.
- R3: Byte index 0 is the byte on the first cycle of each line-valid high period. A byte is kept only when cfg_start_px <= index <= cfg_start_px + cfg_px_m1.
- R4: Only lines 0 to cfg_lines_m1 of a frame produce words. The line count advances at each falling edge of `line_valid`.
- R5: Kept bytes are paired in arrival order. The first byte of a pair goes to out_data[15:8] and the second goes to out_data[7:0].
- R6: `out_sof` is set on the first word of each frame. `out_eol` is set on the word whose second byte has index cfg_start_px + cfg_px_m1.
- R7: While `cfg_wr_en` is 0, no word is produced, but the interrupts still fire.
- R8: Each word is offered for one cycle. If `out_ready` is low in that cycle, the word is dropped and `err_ovf` becomes 1 and stays 1 until reset.
- R9: A kept byte that is still unpaired when its line ends is discarded. In that case `err_odd` becomes 1 and stays 1 until reset.
- R10: `irq_line` pulses for one cycle at the start of line cfg_int_line, including line 0. It never pulses when cfg_int_line > cfg_lines_m1.
- R11: `irq_frame_end` pulses for one cycle after line cfg_lines_m1 ends, which is after that line's last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cam_bus | input | 14 | Sensor data bus |
| frame_valid | input | 1 | Frame qualifier; its falling edge starts a frame |
| line_valid | input | 1 | Line qualifier; high while bytes are valid |
| cfg_shift | input | 2 | Lane select; the shift is twice this value |
| cfg_wr_en | input | 1 | Enables word output |
| cfg_start_px | input | 15 | First kept byte index within a line |
| cfg_px_m1 | input | 15 | Kept bytes per line minus one |
| cfg_lines_m1 | input | 15 | Kept lines per frame minus one |
| cfg_int_line | input | 15 | Line whose start raises irq_line |
| out_valid | output | 1 | Word offered this cycle |
| out_ready | input | 1 | Sink accepts the offered word |
| out_data | output | 16 | Packed byte pair |
| out_sof | output | 1 | First word of the frame |
| out_eol | output | 1 | Last word of the line window |
| irq_line | output | 1 | Programmed-line pulse |
| irq_frame_end | output | 1 | Last-kept-line-done pulse |
| err_odd | output | 1 | Sticky: an unpaired byte was discarded |
| err_ovf | output | 1 | Sticky: a word was dropped by back-pressure |

## Verification
Suppose the pixel counter is off by one, the pair holder is stale, or the lane mux is wrong. The stream then carries wrong word contents, or it carries extra or missing words, and the scoreboard sees this at the first word of the affected line, about two cycles after the byte enters. A line counter that fails to reset at frame start shows up in a different way. The line pulse fires after the wrong number of completed lines, and the frame-end pulse arrives out of place, both within the same frame. Faults in the sticky error flags are seen at the end-of-frame checks that follow the provoking stimulus.

// File: rtl/cam_capture_pkg.sv
package cam_capture_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef struct packed {
    logic              keep;
    logic [BYTE_W-1:0] data;
    logic              last;
  } beat_t;
endpackage

// File: rtl/cam_lane_sel.sv
module cam_lane_sel #(
  parameter int unsigned BUS_W = 14,
  parameter int unsigned SEL_W = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [BUS_W-1:0]                    bus,
  input  logic                                fv,
  input  logic                                lv,
  input  logic [SEL_W-1:0]                    sel,
  output logic [cam_capture_pkg::BYTE_W-1:0]  byte_q,
  output logic                                fv_q,
  output logic                                lv_q
);
  import cam_capture_pkg::*;
  localparam int unsigned NLANE = (BUS_W - BYTE_W) / 2 + 1;

  logic [BYTE_W-1:0] lanes [NLANE];
  logic [BYTE_W-1:0] pick;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lanes[g] = bus[2*g +: BYTE_W];
  end

  always_comb begin
    pick = lanes[0];
    for (int k = 0; k < NLANE; k++)
      if (int'(sel) == k) pick = lanes[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      fv_q   <= 1'b0;
      lv_q   <= 1'b0;
    end else begin
      byte_q <= pick;
      fv_q   <= fv;
      lv_q   <= lv;
    end
  end
endmodule

// File: rtl/cam_sync_track.sv
module cam_sync_track #(
  parameter int unsigned CNT_W = 15
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                fv_q,
  input  logic                                lv_q,
  input  logic [cam_capture_pkg::BYTE_W-1:0]  byte_q,
  input  logic                                wr_en,
  input  logic [CNT_W-1:0]                    start_px,
  input  logic [CNT_W-1:0]                    px_m1,
  input  logic [CNT_W-1:0]                    lines_m1,
  input  logic [CNT_W-1:0]                    int_line,
  output cam_capture_pkg::beat_t              beat,
  output logic                                frame_start,
  output logic                                line_end,
  output logic                                irq_line,
  output logic                                irq_frame_end
);
  import cam_capture_pkg::*;
  localparam int unsigned PIX_W = CNT_W + 1;

  logic             fv_d, lv_d, in_frame;
  logic             line_rise;
  logic [PIX_W-1:0] pix_cnt, idx, win_end;
  logic [CNT_W-1:0] line_cnt;
  logic             line_in_win;

  assign frame_start = fv_d & ~fv_q;
  assign line_rise   = lv_q & ~lv_d;
  assign line_end    = ~lv_q & lv_d;
  assign idx         = line_rise ? '0 : pix_cnt;
  assign win_end     = {1'b0, start_px} + {1'b0, px_m1};
  assign line_in_win = in_frame && (line_cnt <= lines_m1);

  always_comb begin
    beat.data = byte_q;
    beat.last = (idx == win_end);
    beat.keep = lv_q && wr_en && line_in_win &&
                (idx >= {1'b0, start_px}) && (idx <= win_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_d          <= 1'b0;
      lv_d          <= 1'b0;
      in_frame      <= 1'b0;
      pix_cnt       <= '0;
      line_cnt      <= '0;
      irq_line      <= 1'b0;
      irq_frame_end <= 1'b0;
    end else begin
      fv_d <= fv_q;
      lv_d <= lv_q;
      if (lv_q) pix_cnt <= (idx != '1) ? idx + 1'b1 : idx;
      if (frame_start) begin
        in_frame <= 1'b1;
        line_cnt <= '0;
      end else if (line_end && in_frame && line_cnt != '1) begin
        line_cnt <= line_cnt + 1'b1;
      end
      irq_line      <= line_rise && line_in_win && (line_cnt == int_line);
      irq_frame_end <= line_end && in_frame && (line_cnt == lines_m1);
    end
  end
endmodule

// File: rtl/cam_pack.sv
module cam_pack (
  input  logic                                clk,
  input  logic                                rst_n,
  input  cam_capture_pkg::beat_t              beat,
  input  logic                                frame_start,
  input  logic                                line_end,
  input  logic                                out_ready,
  output logic                                out_valid,
  output logic [cam_capture_pkg::WORD_W-1:0]  out_data,
  output logic                                out_sof,
  output logic                                out_eol,
  output logic                                err_odd,
  output logic                                err_ovf
);
  import cam_capture_pkg::*;

  logic              hold_vld, sof_pend;
  logic [BYTE_W-1:0] hold_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_byte <= '0;
      sof_pend  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      err_odd   <= 1'b0;
      err_ovf   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      if (out_valid && !out_ready) err_ovf <= 1'b1;
      if (frame_start) begin
        sof_pend <= 1'b1;
        hold_vld <= 1'b0;
      end else if (beat.keep) begin
        if (!hold_vld) begin
          hold_vld  <= 1'b1;
          hold_byte <= beat.data;
        end else begin
          hold_vld  <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= {hold_byte, beat.data};
          out_sof   <= sof_pend;
          out_eol   <= beat.last;
          sof_pend  <= 1'b0;
        end
      end else if (line_end) begin
        if (hold_vld) err_odd <= 1'b1;
        hold_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cam_capture.sv
module cam_capture #(
  parameter int unsigned BUS_W = 14,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] cam_bus,
  input  logic             frame_valid,
  input  logic             line_valid,
  input  logic [SEL_W-1:0] cfg_shift,
  input  logic             cfg_wr_en,
  input  logic [CNT_W-1:0] cfg_start_px,
  input  logic [CNT_W-1:0] cfg_px_m1,
  input  logic [CNT_W-1:0] cfg_lines_m1,
  input  logic [CNT_W-1:0] cfg_int_line,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [15:0]      out_data,
  output logic             out_sof,
  output logic             out_eol,
  output logic             irq_line,
  output logic             irq_frame_end,
  output logic             err_odd,
  output logic             err_ovf
);
  import cam_capture_pkg::*;

  logic [BYTE_W-1:0] byte_q;
  logic              fv_q, lv_q, frame_start, line_end;
  beat_t             beat;

  cam_lane_sel #(.BUS_W(BUS_W), .SEL_W(SEL_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .bus(cam_bus), .fv(frame_valid),
    .lv(line_valid), .sel(cfg_shift), .byte_q(byte_q), .fv_q(fv_q), .lv_q(lv_q)
  );

  cam_sync_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .fv_q(fv_q), .lv_q(lv_q), .byte_q(byte_q),
    .wr_en(cfg_wr_en), .start_px(cfg_start_px), .px_m1(cfg_px_m1),
    .lines_m1(cfg_lines_m1), .int_line(cfg_int_line), .beat(beat),
    .frame_start(frame_start), .line_end(line_end),
    .irq_line(irq_line), .irq_frame_end(irq_frame_end)
  );

  cam_pack u_pack (
    .clk(clk), .rst_n(rst_n), .beat(beat), .frame_start(frame_start),
    .line_end(line_end), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol),
    .err_odd(err_odd), .err_ovf(err_ovf)
  );
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr_en,
  input logic line_valid,
  input logic out_valid,
  input logic out_ready,
  input logic out_sof,
  input logic out_eol,
  input logic irq_line,
  input logic irq_frame_end,
  input logic err_odd,
  input logic err_ovf
);
  p_flags_need_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eol) |-> out_valid);
  p_no_write_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(cfg_wr_en));
  p_word_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |=> err_ovf);
  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovf) |-> $past(out_valid && !out_ready));
  p_odd_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_odd |=> err_odd);
  p_odd_after_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_odd) |-> !line_valid);
  p_irq_line_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line |=> !irq_line);
  p_irq_end_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frame_end |=> !irq_frame_end);
endmodule

bind cam_capture cam_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .line_valid(line_valid),
  .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
  .out_eol(out_eol), .irq_line(irq_line), .irq_frame_end(irq_frame_end),
  .err_odd(err_odd), .err_ovf(err_ovf)
);

// File: tb/cam_capture_test.sv
module cam_capture_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] d;
    logic        s;
    logic        e;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] cam_bus = '0;
  logic        frame_valid = 1'b0, line_valid = 1'b0;
  logic [1:0]  cfg_shift = '0;
  logic        cfg_wr_en = 1'b1;
  logic [14:0] cfg_start_px = '0, cfg_px_m1 = '0, cfg_lines_m1 = '0, cfg_int_line = '0;
  logic        out_ready = 1'b1;
  logic        out_valid, out_sof, out_eol, irq_line, irq_frame_end, err_odd, err_ovf;
  logic [15:0] out_data;

  int errors = 0, checks = 0;
  bit done = 0;
  exp_t q[$];
  int eol_seen = 0, vd0_cnt = 0, vd0_at = -1, vd1_cnt = 0, vd1_at = -1;
  int exp_vd0_at, exp_vd1_at, frame_no = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_capture uut (
    .clk(clk), .rst_n(rst_n), .cam_bus(cam_bus), .frame_valid(frame_valid),
    .line_valid(line_valid), .cfg_shift(cfg_shift), .cfg_wr_en(cfg_wr_en),
    .cfg_start_px(cfg_start_px), .cfg_px_m1(cfg_px_m1), .cfg_lines_m1(cfg_lines_m1),
    .cfg_int_line(cfg_int_line), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol), .irq_line(irq_line),
    .irq_frame_end(irq_frame_end), .err_odd(err_odd), .err_ovf(err_ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on every accepted word, interrupt bookkeeping
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(0, "R2/R3/R4/R7", "unexpected word", int'(out_data), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_data == e.d, "R1/R5", "word data", int'(out_data), int'(e.d));
          chk(out_sof == e.s, "R6", "sof flag", int'(out_sof), int'(e.s));
          chk(out_eol == e.e, "R6", "eol flag", int'(out_eol), int'(e.e));
        end
        if (out_eol) eol_seen++;
      end
      if (irq_line) begin vd0_cnt++; vd0_at = eol_seen; end
      if (irq_frame_end) begin vd1_cnt++; vd1_at = eol_seen; end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  function automatic logic [13:0] place(input logic [7:0] b, input logic [1:0] s);
    logic [13:0] m;
    m = 14'(8'hFF) << (2 * s);
    return (14'h2AAA & ~m) | ((14'(b)) << (2 * s));
  endfunction

  task automatic drive_line(input int len, input int l, input int ready_low,
                            input bit count_line, inout bit first, inout int eol_pushed);
    bit have = 0;
    logic [7:0] h = '0;
    int wend = int'(cfg_start_px) + int'(cfg_px_m1);
    if (l == ready_low) out_ready = 1'b0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'(frame_no * 64 + l * 16 + i * 3 + 1);
      if (count_line && cfg_wr_en && l <= int'(cfg_lines_m1) &&
          i >= int'(cfg_start_px) && i <= wend) begin
        if (!have) begin have = 1; h = b; end
        else begin
          have = 0;
          if (l != ready_low) begin
            q.push_back('{d: {h, b}, s: first, e: (i == wend)});
            if (i == wend) eol_pushed++;
          end
          first = 0;
        end
      end
      line_valid = 1'b1;
      cam_bus = place(b, cfg_shift);
      tick();
    end
    line_valid = 1'b0;
    cam_bus = '0;
    repeat (6) tick();
    out_ready = 1'b1;
  endtask

  task automatic drive_frame(input int nlines, input int len, input int ready_low);
    bit first = 1;
    int eol_pushed = 0;
    eol_seen = 0; vd0_cnt = 0; vd0_at = -1; vd1_cnt = 0; vd1_at = -1;
    exp_vd0_at = -1; exp_vd1_at = -1;
    frame_valid = 1'b1;
    repeat (3) tick();
    frame_valid = 1'b0;
    repeat (3) tick();
    for (int l = 0; l < nlines; l++) begin
      if (l == int'(cfg_int_line)) exp_vd0_at = eol_pushed;
      drive_line(len, l, ready_low, 1'b1, first, eol_pushed);
      if (l == int'(cfg_lines_m1)) exp_vd1_at = eol_pushed;
    end
    repeat (8) tick();
    chk(q.size() == 0, "R3/R4", "missing words at frame end", q.size(), 0);
    q.delete();
    frame_no++;
  endtask

  task automatic check_irqs(input int nlines);
    bit vd0_exp = int'(cfg_int_line) <= int'(cfg_lines_m1) && int'(cfg_int_line) < nlines;
    chk(vd0_cnt == int'(vd0_exp), "R10", "line irq count", vd0_cnt, int'(vd0_exp));
    if (vd0_exp) chk(vd0_at == exp_vd0_at, "R10", "line irq position (eol before)", vd0_at, exp_vd0_at);
    chk(vd1_cnt == 1, "R11", "frame-end irq count", vd1_cnt, 1);
    chk(vd1_at == exp_vd1_at, "R11", "frame-end irq position", vd1_at, exp_vd1_at);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    bit f = 1;
    int ep = 0;
    repeat (3) tick();
    chk(out_valid == 0, "R2", "reset out_valid", int'(out_valid), 0);
    chk(irq_line == 0 && irq_frame_end == 0, "R2", "reset irqs", int'(irq_line), 0);
    chk(err_odd == 0 && err_ovf == 0, "R8/R9", "reset error flags", int'(err_odd | err_ovf), 0);
    rst_n = 1'b1;
    repeat (2) tick();

    // R2: a line before any frame start produces nothing
    drive_line(6, 0, -1, 1'b0, f, ep);
    chk(vd0_cnt == 0 && vd1_cnt == 0, "R2", "irq before first frame", vd0_cnt + vd1_cnt, 0);

    // Frame 1: lane [13:6], window 2..7, 3 lines kept of 4, irq on line 0 (R1 R3 R4 R5 R6 R10)
    cfg_shift = 2'd3; cfg_start_px = 15'd2; cfg_px_m1 = 15'd5;
    cfg_lines_m1 = 15'd2; cfg_int_line = 15'd0;
    drive_frame(4, 10, -1);
    check_irqs(4);
    chk(err_ovf == 0, "R8", "no overflow with ready high", int'(err_ovf), 0);
    chk(err_odd == 0, "R9", "no odd error on even window", int'(err_odd), 0);

    // Frame 2: lane [7:0], full-line window, ready low on line 1 (R8), irq on line 2
    cfg_shift = 2'd0; cfg_start_px = 15'd0; cfg_px_m1 = 15'd7;
    cfg_lines_m1 = 15'd3; cfg_int_line = 15'd2;
    drive_frame(4, 8, 1);
    check_irqs(4);
    chk(err_ovf == 1, "R8", "overflow after dropped words", int'(err_ovf), 1);

    // Frame 3: write disabled, irq line beyond window (R7 R10)
    cfg_shift = 2'd1; cfg_wr_en = 1'b0; cfg_start_px = 15'd1; cfg_px_m1 = 15'd3;
    cfg_lines_m1 = 15'd1; cfg_int_line = 15'd5;
    drive_frame(3, 6, -1);
    check_irqs(3);
    chk(err_ovf == 1, "R8", "overflow flag stays set", int'(err_ovf), 1);

    // Frame 4: line of 5 bytes inside a 10-byte window, last byte unpaired (R9)
    cfg_shift = 2'd2; cfg_wr_en = 1'b1; cfg_start_px = 15'd0; cfg_px_m1 = 15'd9;
    cfg_lines_m1 = 15'd0; cfg_int_line = 15'd0;
    chk(err_odd == 0, "R9", "odd flag clear before odd line", int'(err_odd), 0);
    drive_frame(1, 5, -1);
    check_irqs(1);
    chk(err_odd == 1, "R9", "odd flag after unpaired byte", int'(err_odd), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule